// File: doc/BRIEF.md
# Sequential Correlation Score Engine

This block scores how closely two short sequences of signed samples move together. After a start pulse it steps through both sequences one position per clock. On each step it adds to three running totals: the sum of pairwise products, the sum of squares of the first sequence and the sum of squares of the second. When the last position has been added, it multiplies the two square totals and passes the product to an iterative integer square-root unit. It then passes the signed product total and that root to an iterative divider. The quotient is a correlation score with no fractional scaling.

The samples come either from two parallel input vectors, captured when a run is accepted, or from a fixed internal pattern chosen by a select input. The three totals, the root and the quotient stay on the outputs after the run ends. A one-cycle completion pulse marks the end of each run. If the root is zero, the divide step is skipped and a status flag is raised.

Top module: `corr_engine`

## Requirements
- R1: While reset is held low and in the first cycle after it, every result output, `div_zero`, `busy` and `done` read zero.
- R2: A `start` seen high while idle is accepted on that clock edge. The edge clears the three totals, captures `a_vec`, `b_vec` and `tbl_sel`, and raises `busy`. Sample j (j = 0..N_SAMP-1, processed in that order) is the two's-complement field `vec[j*SAMP_W +: SAMP_W]`.
- R3: Exactly one sample pair is added per clock over N_SAMP consecutive edges. `xsum` is the 32-bit signed wrapping sum of a_j*b_j.
- R4: `asq` and `bsq` are the 32-bit unsigned wrapping sums of a_j*a_j and b_j*b_j.
- R5: `root` is floor(sqrt(P)), where P = (asq*bsq) mod 2^32. `root` is ROOT_W bits wide.
- R6: When `root` is nonzero, `quot` is `xsum` divided by `root`, truncated toward zero, and `div_zero` is 0.
- R7: When `root` is zero, the divider is not run, `quot` is 0 and `div_zero` is 1. The flag is cleared by the next accepted start.
- R8: `done` is high for exactly one cycle. With the start edge counted as edge 0, it goes high after edge N_SAMP+ROOT_W+ACC_W+3 (nonzero root) or after edge N_SAMP+ROOT_W+2 (zero root). `busy` falls at the next edge.
- R9: A `start` pulse while `busy` is high has no effect: the run in progress finishes with its captured samples and its latency unchanged.
- R10: Between the end of a run and the next accepted start, all result outputs hold their values, whatever `a_vec`, `b_vec` and `tbl_sel` do.
- R11: With `tbl_sel` = 1 captured, the input vectors are ignored and sample j is a_j = ((5*j+1) mod 9) - 4 and b_j = -a_j. For 10 samples this gives xsum = -69, asq = bsq = 69, root = 69 and quot = -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, accepted only when idle |
| tbl_sel | input | 1 | 1 selects the internal sample pattern |
| a_vec | input | N_SAMP*SAMP_W | First sequence, sample j in bits j*SAMP_W upward |
| b_vec | input | N_SAMP*SAMP_W | Second sequence, same packing |
| xsum | output | ACC_W | Signed sum of cross products |
| asq | output | ACC_W | Sum of squares of the first sequence |
| bsq | output | ACC_W | Sum of squares of the second sequence |
| root | output | ROOT_W | Integer square root of the square-sum product |
| quot | output | ACC_W | Signed correlation quotient |
| div_zero | output | 1 | Root was zero, divide skipped |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench uses the default parameters: ten 8-bit samples, 32-bit totals and a 16-bit root. With these widths, sequences of -128 and 127 push the product of the square sums past 2^32, so the wrap in R5 is tested. The full 32-step divide and the 16-step root are exercised at their real lengths, so the latency rule of R8 is checked on both the divide and the skip path. Because the root and divider lengths follow ROOT_W and ACC_W, a narrower build would shorten runs but would no longer reach the product wrap.

// File: rtl/corr_pkg.sv
package corr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_REDUCE,
    ST_ROOT,
    ST_DIV,
    ST_FIN
  } corr_state_e;

  // Built-in sample pattern; the second sequence is its negation.
  function automatic int tbl_entry(input int j);
    return ((5 * j + 1) % 9) - 4;
  endfunction

endpackage

// File: rtl/corr_mac.sv
module corr_mac #(
  parameter int SAMP_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic signed [SAMP_W-1:0] a_s,
  input  logic signed [SAMP_W-1:0] b_s,
  output logic signed [ACC_W-1:0]  xsum,
  output logic        [ACC_W-1:0]  asq,
  output logic        [ACC_W-1:0]  bsq
);
  localparam int PW = 2 * SAMP_W;

  function automatic logic signed [ACC_W-1:0] cross_term(
    input logic signed [SAMP_W-1:0] x, input logic signed [SAMP_W-1:0] y);
    logic signed [PW-1:0] p;
    p = x * y;
    return ACC_W'(p);
  endfunction

  function automatic logic [ACC_W-1:0] square_term(
    input logic signed [SAMP_W-1:0] x);
    logic signed [PW-1:0] p;
    p = x * x;
    return ACC_W'($unsigned(p));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      xsum <= '0;
      asq  <= '0;
      bsq  <= '0;
    end else if (step) begin
      xsum <= xsum + cross_term(a_s, b_s);
      asq  <= asq + square_term(a_s);
      bsq  <= bsq + square_term(b_s);
    end
  end

endmodule

// File: rtl/corr_isqrt.sv
module corr_isqrt #(
  parameter int RW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [2*RW-1:0] opnd,
  output logic [RW-1:0]   root,
  output logic            fin
);
  localparam int OW    = 2 * RW;
  localparam int REM_W = RW + 2;
  localparam int CW    = $clog2(RW + 1);

  logic [OW-1:0]    op_q;
  logic [REM_W-1:0] rem_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;

  // One restoring digit: bring down two operand bits, try subtracting 4q+1.
  function automatic logic [REM_W+RW-1:0] root_step(
    input logic [REM_W-1:0] r, input logic [RW-1:0] q, input logic [1:0] pr);
    logic [REM_W-1:0] sh;
    logic [REM_W-1:0] trial;
    sh    = {r[REM_W-3:0], pr};
    trial = {q, 2'b01};
    if (sh >= trial) return {sh - trial, q[RW-2:0], 1'b1};
    else             return {sh, q[RW-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= '0;
      rem_q <= '0;
      root  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        op_q  <= opnd;
        rem_q <= '0;
        root  <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        {rem_q, root} <= root_step(rem_q, root, op_q[OW-1 -: 2]);
        op_q  <= op_q << 2;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(RW - 1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/corr_udiv.sv
module corr_udiv #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          fin
);
  localparam int REM_W = DW + 1;
  localparam int CW    = $clog2(NW + 1);

  logic [REM_W-1:0] rem_q;
  logic [DW-1:0]    den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;

  // One restoring step: quo shifts the dividend out and quotient bits in.
  function automatic logic [REM_W+NW-1:0] div_step(
    input logic [REM_W-1:0] r, input logic [NW-1:0] q, input logic [DW-1:0] d);
    logic [REM_W-1:0] sh;
    sh = {r[DW-1:0], q[NW-1]};
    if (sh >= {1'b0, d}) return {sh - {1'b0, d}, q[NW-2:0], 1'b1};
    else                 return {sh, q[NW-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo   <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quo   <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        {rem_q, quo} <= div_step(rem_q, quo, den_q);
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/corr_engine.sv
module corr_engine #(
  parameter int N_SAMP = 10,
  parameter int SAMP_W = 8,
  parameter int ACC_W  = 32,
  parameter int ROOT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     tbl_sel,
  input  logic [N_SAMP*SAMP_W-1:0] a_vec,
  input  logic [N_SAMP*SAMP_W-1:0] b_vec,
  output logic signed [ACC_W-1:0]  xsum,
  output logic [ACC_W-1:0]         asq,
  output logic [ACC_W-1:0]         bsq,
  output logic [ROOT_W-1:0]        root,
  output logic signed [ACC_W-1:0]  quot,
  output logic                     div_zero,
  output logic                     busy,
  output logic                     done
);
  import corr_pkg::*;

  localparam int VEC_W = N_SAMP * SAMP_W;
  localparam int IDX_W = $clog2(N_SAMP + 1);
  localparam int OP_W  = 2 * ROOT_W;

  corr_state_e st_q;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] a_q, b_q;
  logic             tbl_q;

  // Named internal events, also observed by the checker.
  logic             accept, acc_step, last_idx, root_go, root_fin, div_go, div_fin;
  logic [ACC_W-1:0] prod_w;
  logic [OP_W-1:0]  root_op;
  logic [ACC_W-1:0] div_num, div_quo;

  logic signed [SAMP_W-1:0] a_arr [N_SAMP];
  logic signed [SAMP_W-1:0] b_arr [N_SAMP];
  logic signed [SAMP_W-1:0] a_s, b_s;

  for (genvar g = 0; g < N_SAMP; g++) begin : g_samp
    logic signed [SAMP_W-1:0] ta, tb;
    assign ta       = SAMP_W'(tbl_entry(g));
    assign tb       = SAMP_W'(-tbl_entry(g));
    assign a_arr[g] = tbl_q ? ta : a_q[g*SAMP_W +: SAMP_W];
    assign b_arr[g] = tbl_q ? tb : b_q[g*SAMP_W +: SAMP_W];
  end

  assign a_s      = a_arr[idx];
  assign b_s      = b_arr[idx];
  assign accept   = start && (st_q == ST_IDLE);
  assign acc_step = (st_q == ST_ACC);
  assign last_idx = acc_step && (idx == IDX_W'(N_SAMP - 1));
  assign root_go  = (st_q == ST_REDUCE);
  assign prod_w   = asq * bsq;
  assign root_op  = OP_W'(prod_w);
  assign div_go   = (st_q == ST_ROOT) && root_fin && (root != '0);
  assign div_num  = xsum[ACC_W-1] ? ACC_W'(-xsum) : ACC_W'(xsum);
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);

  corr_mac #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(acc_step),
    .a_s(a_s), .b_s(b_s), .xsum(xsum), .asq(asq), .bsq(bsq)
  );

  corr_isqrt #(.RW(ROOT_W)) u_root (
    .clk(clk), .rst_n(rst_n), .go(root_go), .opnd(root_op),
    .root(root), .fin(root_fin)
  );

  corr_udiv #(.NW(ACC_W), .DW(ROOT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(root),
    .quo(div_quo), .fin(div_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx      <= '0;
      a_q      <= '0;
      b_q      <= '0;
      tbl_q    <= 1'b0;
      quot     <= '0;
      div_zero <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          idx      <= '0;
          a_q      <= a_vec;
          b_q      <= b_vec;
          tbl_q    <= tbl_sel;
          div_zero <= 1'b0;
          st_q     <= ST_ACC;
        end
        ST_ACC: begin
          if (last_idx) st_q <= ST_REDUCE;
          else          idx  <= idx + 1'b1;
        end
        ST_REDUCE: st_q <= ST_ROOT;
        ST_ROOT: if (root_fin) begin
          if (root == '0) begin
            quot     <= '0;
            div_zero <= 1'b1;
            st_q     <= ST_FIN;
          end else begin
            st_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_fin) begin
          quot <= xsum[ACC_W-1] ? -$signed(div_quo) : $signed(div_quo);
          st_q <= ST_FIN;
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/corr_engine_chk.sv
module corr_engine_chk #(
  parameter int N_SAMP = 10,
  parameter int ACC_W  = 32,
  parameter int ROOT_W = 16,
  parameter int IDX_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    div_zero,
  input logic signed [ACC_W-1:0] xsum,
  input logic [ACC_W-1:0]        asq,
  input logic [ACC_W-1:0]        bsq,
  input logic [ROOT_W-1:0]       root,
  input logic signed [ACC_W-1:0] quot,
  input logic                    acc_step,
  input logic [IDX_W-1:0]        idx,
  input logic                    root_fin,
  input logic [2*ROOT_W-1:0]     root_op
);
  localparam int SQ_W = 2 * ROOT_W + 2;

  logic [SQ_W-1:0] rx, lo_sq, hi_sq, opx;
  assign rx    = SQ_W'(root);
  assign lo_sq = rx * rx;
  assign hi_sq = (rx + 1'b1) * (rx + 1'b1);
  assign opx   = SQ_W'(root_op);

  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_step |-> (idx < IDX_W'(N_SAMP)));

  assert_root_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    root_fin |-> ((lo_sq <= opx) && (hi_sq > opx)));

  assert_quot_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && (quot != '0)) |-> (quot[ACC_W-1] == xsum[ACC_W-1]));

  assert_zero_root_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ((quot == '0) && (root == '0)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_step && start && (idx != IDX_W'(N_SAMP - 1))) |=> (idx == $past(idx) + 1'b1));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(xsum) && $stable(asq) && $stable(bsq) &&
                           $stable(root) && $stable(quot) && $stable(div_zero)));

endmodule

bind corr_engine corr_engine_chk #(
  .N_SAMP(N_SAMP), .ACC_W(ACC_W), .ROOT_W(ROOT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_zero(div_zero), .xsum(xsum), .asq(asq), .bsq(bsq), .root(root),
  .quot(quot), .acc_step(acc_step), .idx(idx), .root_fin(root_fin),
  .root_op(root_op)
);

// File: tb/corr_engine_bench.sv
module corr_engine_bench;
  localparam int N  = 10;
  localparam int W  = 8;
  localparam int AW = 32;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tbl_sel = 1'b0;
  logic [N*W-1:0] a_vec = '0, b_vec = '0;
  logic signed [AW-1:0] xsum, quot;
  logic [AW-1:0] asq, bsq;
  logic [RW-1:0] root;
  logic div_zero, busy, done;

  always #4 clk = ~clk;

  corr_engine #(.N_SAMP(N), .SAMP_W(W), .ACC_W(AW), .ROOT_W(RW)) u_corr_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_sel(tbl_sel),
    .a_vec(a_vec), .b_vec(b_vec), .xsum(xsum), .asq(asq), .bsq(bsq),
    .root(root), .quot(quot), .div_zero(div_zero), .busy(busy), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  int va [N];
  int vb [N];
  longint e_xs, e_sa, e_sb, e_root, e_quot;
  bit e_dz;
  int exp_lat = 0;
  bit finished = 0;

  // Behavioural model of the run timing: one countdown per accepted start.
  bit m_busy = 0;
  int m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0;
      m_left <= 0;
    end else if (m_busy) begin
      if (m_left == 0) m_busy <= 0;
      else             m_left <= m_left - 1;
    end else if (start) begin
      m_busy <= 1;
      m_left <= exp_lat;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_results(input string req);
    check(req, "xsum", longint'(xsum), e_xs);
    check(req, "asq", longint'(asq), e_sa);
    check(req, "bsq", longint'(bsq), e_sb);
    check(req, "root", longint'(root), e_root);
    check(req, "quot", longint'(quot), e_quot);
    check(req, "div_zero", longint'(div_zero), longint'(e_dz));
  endtask

  // Compared on every clock: busy and done against the model (R8, R9);
  // results when done is expected (R3..R7, R11).
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8", "busy", longint'(busy), longint'(m_busy));
      check("R8", "done", longint'(done), longint'(m_busy && m_left == 0));
      if (m_busy && m_left == 0) check_results("R3/R4/R5/R6/R7/R11");
    end
  end

  task automatic pack();
    for (int j = 0; j < N; j++) begin
      a_vec[j*W +: W] = W'(va[j]);
      b_vec[j*W +: W] = W'(vb[j]);
    end
  endtask

  task automatic calc(input bit use_tbl);
    longint p, r;
    int ea, eb;
    e_xs = 0; e_sa = 0; e_sb = 0;
    for (int j = 0; j < N; j++) begin
      ea = use_tbl ? ((5 * j + 1) % 9) - 4 : va[j];
      eb = use_tbl ? -ea : vb[j];
      e_xs += longint'(ea * eb);
      e_sa += longint'(ea * ea);
      e_sb += longint'(eb * eb);
    end
    e_xs = longint'(int'(e_xs));
    e_sa = e_sa & 64'hFFFF_FFFF;
    e_sb = e_sb & 64'hFFFF_FFFF;
    p = (e_sa * e_sb) & 64'hFFFF_FFFF;
    r = 0;
    for (int b = RW - 1; b >= 0; b--)
      if ((r + (64'd1 << b)) * (r + (64'd1 << b)) <= p) r += (64'd1 << b);
    e_root = r;
    e_dz   = (r == 0);
    e_quot = (r == 0) ? 0 : e_xs / r;
    exp_lat = (r == 0) ? N + RW + 2 : N + RW + AW + 3;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!m_busy) break;
    end
  endtask

  task automatic run_case(input bit use_tbl, input bit poke);
    calc(use_tbl);
    @(negedge clk);
    tbl_sel = use_tbl;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    if (poke) begin
      // R9: a second start while busy, with different vectors and selector
      repeat (4) @(negedge clk);
      a_vec   = ~a_vec;
      b_vec   = {N*W{1'b1}};
      tbl_sel = ~use_tbl;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      repeat (30) @(negedge clk);
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
    end
    wait_idle();
  endtask

  task automatic final_report();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    final_report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1", "xsum", longint'(xsum), 0);
    check("R1", "quot", longint'(quot), 0);
    check("R1", "root", longint'(root), 0);
    check("R1", "flags", longint'({div_zero, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "asq", longint'(asq), 0);
    check("R1", "bsq", longint'(bsq), 0);

    // R11: internal pattern, input vectors hold junk that must be ignored
    for (int j = 0; j < N; j++) begin va[j] = 100; vb[j] = 100; end
    pack();
    run_case(1'b1, 1'b0);
    check("R11", "quot", longint'(quot), -1);
    check("R11", "root", longint'(root), 69);

    // R7: all zero sequences, divide skipped
    for (int j = 0; j < N; j++) begin va[j] = 0; vb[j] = 0; end
    pack();
    run_case(1'b0, 1'b0);
    check("R7", "div_zero", longint'(div_zero), 1);

    // R2/R6: positive relation, div_zero cleared by the new start (R7)
    for (int j = 0; j < N; j++) begin va[j] = j + 1; vb[j] = (j * 7) % 11 - 3; end
    pack();
    run_case(1'b0, 1'b0);
    check("R7", "div_zero cleared", longint'(div_zero), 0);

    // R5: extremes wrap the square-sum product past 32 bits
    for (int j = 0; j < N; j++) begin va[j] = -128; vb[j] = 127; end
    pack();
    run_case(1'b0, 1'b0);

    // R7: one sequence zero, the other not
    for (int j = 0; j < N; j++) begin va[j] = j - 5; vb[j] = 0; end
    pack();
    run_case(1'b0, 1'b0);

    // R9: mixed signs with starts issued while busy
    va = '{-5, 7, -3, 0, 12, -9, 4, 1, -2, 6};
    vb = '{4, -6, 2, 1, -10, 8, -3, 0, 3, -5};
    pack();
    run_case(1'b0, 1'b1);

    // R10: inputs change with no start, results must not move
    a_vec = {N*W{1'b1}};
    b_vec = '0;
    tbl_sel = 1'b1;
    repeat (12) @(negedge clk);
    check_results("R10");

    final_report();
  end

endmodule